// File: doc/BRIEF.md
# Serial Signed Decimal Field Adder

This block adds one signed decimal field to another, or subtracts one from the other, where both fields live in a character-wide memory. A start strobe supplies the address of each field's units (rightmost) character and an add/subtract select. The block then walks both fields one digit per step, from the units position toward lower addresses. It writes each result digit back over the B-field and stops at the B-field's word mark.

The sign of each operand is carried in the zone bits of its units character. The number of minus signs (the two operand signs, plus one for a subtract) selects the pass type. An even count gives a straight decimal add. An odd count gives an add of the nines complement of the A digits. When a complement pass ends without a final carry, the stored result is in complement form. A second pass then rewrites the B-field in true form and flips its sign. A carry out of the top digit of a straight add sets a sticky overflow flag and marks the top B character. One cycle after the last write, a done pulse tells the caller the field is final.

Top module: `dec_field_adder`

## Requirements
- R1: A character is 7 bits: bit 6 is the word mark, bits 5:4 are the zone pair {B, A}, and bits 3:0 are the numeric code. A units zone of 2'b10 means minus and any other zone means plus. A numeric code above 9, such as a blank, reads as digit zero.
- R2: When the count of minus signs (A sign, B sign, and one more for subtract) is even, the B-field receives the decimal sum of the two magnitudes.
- R3: When that count is odd and |B| >= |A|, the B-field receives |B| - |A| and carries the sign of B. An equal-magnitude result is therefore a zero carrying B's sign.
- R4: When that count is odd and |B| < |A|, a recomplement pass runs after the first pass. The B-field then holds |A| - |B| in true form, with the sign opposite to B's.
- R5: After a straight add, the result carries the sign of B. The units character is written with zone 2'b11 for plus or 2'b10 for minus.
- R6: In a straight add on a B-field of two or more positions, a carry out of the high-order digit sets the overflow output. It also writes zone 2'b01 on the high-order B character, and the stored digits keep the sum modulo 10^LB.
- R7: A one-position B-field never raises overflow. Its single character holds the sign zone.
- R8: The B-field word mark ends the operation. A-digits beyond a shorter A-field's word mark count as zero, and A positions beyond the B-field length are ignored. No character outside the B-field is written.
- R9: Every written B character keeps its word-mark bit and holds a digit from 0 to 9. Every position except the units position and the overflow-marked high-order position has zone 2'b00.
- R10: Overflow stays set until clr_ovf is pulsed. A clear takes effect on the next cycle unless a new overflow is set in the same cycle.
- R11: done is a single-cycle pulse that appears 3*LB+1 cycles after the start cycle, or 5*LB+1 cycles when a recomplement pass runs. Reads and writes never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (one-cycle strobe while idle) |
| sub | input | 1 | 1 = subtract A from B, 0 = add A to B |
| a_addr | input | ADDR_W | Address of A-field units character |
| b_addr | input | ADDR_W | Address of B-field units character |
| clr_ovf | input | 1 | Clears the overflow flag |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read request, data returned next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 7 | Write character |
| mem_rdata | input | 7 | Read character |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Directed cases pair the same magnitudes under all sign and operation combinations. This separates straight adds, complement adds that end with a carry, and complement adds that need a recomplement pass, and the done latency shows which pass ran. Dedicated cases cover carry past the top digit on multi-digit and single-digit fields, A-fields shorter and longer than B, and a field operated on itself (including the minus-zero result). Random cases add noisy zones, blank digits and alternative plus codes, so that sign decoding and zone cleanup are exercised against a model computed from signed integers.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
   localparam int CHAR_W = 7;
   localparam int NUM_W  = 4;

   typedef struct packed {
      logic             wm;
      logic [1:0]       zone;
      logic [NUM_W-1:0] num;
   } dchar_t;

   localparam logic [1:0] ZN_PLUS  = 2'b11;
   localparam logic [1:0] ZN_MINUS = 2'b10;
   localparam logic [1:0] ZN_OVF   = 2'b01;
   localparam logic [1:0] ZN_NONE  = 2'b00;

   function automatic logic [NUM_W-1:0] num_val(input logic [NUM_W-1:0] n);
      return (n > 4'd9) ? '0 : n;
   endfunction

   function automatic logic zone_neg(input logic [1:0] z);
      return z == ZN_MINUS;
   endfunction
endpackage

// File: rtl/dec_digit_add.sv
module dec_digit_add #(
   parameter bit SIX_CORRECT = 1'b1
) (
   input  logic [3:0] add_a,
   input  logic [3:0] add_b,
   input  logic       nines,
   input  logic       cin,
   output logic [3:0] sum,
   output logic       cout
);
   logic [3:0] a_eff;
   logic [4:0] raw;

   always_comb begin
      a_eff = nines ? (4'd9 - add_a) : add_a;
      raw   = {1'b0, a_eff} + {1'b0, add_b} + {4'b0000, cin};
   end

   generate
      if (SIX_CORRECT) begin : g_six
         logic [4:0] adj;
         always_comb begin
            adj  = raw + 5'd6;
            cout = raw > 5'd9;
            sum  = cout ? adj[3:0] : raw[3:0];
         end
      end else begin : g_ten
         always_comb begin
            cout = raw > 5'd9;
            sum  = cout ? (raw[3:0] - 4'd10) : raw[3:0];
         end
      end
   endgenerate
endmodule

// File: rtl/dec_sign_sel.sv
module dec_sign_sel
   import dfa_pkg::*;
(
   input  logic [1:0] a_zone,
   input  logic [1:0] b_zone,
   input  logic       sub,
   output logic       use_nines,
   output logic       b_neg
);
   logic a_neg;

   always_comb begin
      a_neg     = zone_neg(a_zone);
      b_neg     = zone_neg(b_zone);
      use_nines = a_neg ^ b_neg ^ sub;
   end
endmodule

// File: rtl/dec_field_adder.sv
module dec_field_adder
   import dfa_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter bit SIX_CORRECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sub,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              clr_ovf,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [CHAR_W-1:0] mem_wdata,
   input  logic [CHAR_W-1:0] mem_rdata,
   output logic              done,
   output logic              ovf
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr
         $error("dec_field_adder: ADDR_W out of range");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_RDA, S_RDB, S_WRB, S_RCRD, S_RCWR, S_FIN
   } st_t;

   st_t               st;
   logic [ADDR_W-1:0] a_ptr, b_ptr, b_unit;
   logic              op_sub, a_end, first, cmpl, carry, res_neg, ovf_q;
   dchar_t            a_q;
   dchar_t            rd_ch;
   dchar_t            wr_ch;
   logic              nines_new, b_neg_new, use_nines;
   logic [3:0]        add_a, add_b, add_sum;
   logic              add_n, add_c, add_cout, ovf_hit;

   assign rd_ch = dchar_t'(mem_rdata);

   dec_sign_sel u_sign (
      .a_zone    (a_q.zone),
      .b_zone    (rd_ch.zone),
      .sub       (op_sub),
      .use_nines (nines_new),
      .b_neg     (b_neg_new)
   );

   always_comb begin
      use_nines = first ? nines_new : cmpl;
      if (st == S_RCWR) begin
         add_a = num_val(rd_ch.num);
         add_b = 4'd0;
         add_n = 1'b1;
         add_c = carry;
      end else begin
         add_a = num_val(a_q.num);
         add_b = num_val(rd_ch.num);
         add_n = use_nines;
         add_c = first ? nines_new : carry;
      end
   end

   dec_digit_add #(.SIX_CORRECT(SIX_CORRECT)) u_digit (
      .add_a (add_a),
      .add_b (add_b),
      .nines (add_n),
      .cin   (add_c),
      .sum   (add_sum),
      .cout  (add_cout)
   );

   always_comb begin
      ovf_hit  = (st == S_WRB) && !first && !cmpl && rd_ch.wm && add_cout;
      wr_ch.wm = rd_ch.wm;
      wr_ch.num = add_sum;
      if (st == S_WRB) begin
         if (first)        wr_ch.zone = b_neg_new ? ZN_MINUS : ZN_PLUS;
         else if (ovf_hit) wr_ch.zone = ZN_OVF;
         else              wr_ch.zone = ZN_NONE;
      end else begin
         if (first)        wr_ch.zone = res_neg ? ZN_PLUS : ZN_MINUS;
         else              wr_ch.zone = ZN_NONE;
      end
      mem_rd    = (st == S_RDA && !a_end) || st == S_RDB || st == S_RCRD;
      mem_wr    = (st == S_WRB) || (st == S_RCWR);
      mem_addr  = (st == S_RDA) ? a_ptr : b_ptr;
      mem_wdata = wr_ch;
      done      = (st == S_FIN);
      ovf       = ovf_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         a_ptr   <= '0;
         b_ptr   <= '0;
         b_unit  <= '0;
         op_sub  <= 1'b0;
         a_end   <= 1'b0;
         first   <= 1'b0;
         cmpl    <= 1'b0;
         carry   <= 1'b0;
         res_neg <= 1'b0;
         a_q     <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (ovf_hit)      ovf_q <= 1'b1;
         else if (clr_ovf) ovf_q <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               a_ptr  <= a_addr;
               b_ptr  <= b_addr;
               b_unit <= b_addr;
               op_sub <= sub;
               a_end  <= 1'b0;
               first  <= 1'b1;
               st     <= S_RDA;
            end
            S_RDA: st <= S_RDB;
            S_RDB: begin
               a_q <= a_end ? '0 : rd_ch;
               st  <= S_WRB;
            end
            S_WRB: begin
               first <= 1'b0;
               if (first) begin
                  cmpl    <= nines_new;
                  res_neg <= b_neg_new;
               end
               carry <= add_cout;
               a_end <= a_end | a_q.wm;
               a_ptr <= a_ptr - STEP;
               b_ptr <= b_ptr - STEP;
               if (rd_ch.wm) begin
                  if (use_nines && !add_cout) begin
                     b_ptr <= b_unit;
                     carry <= 1'b1;
                     first <= 1'b1;
                     st    <= S_RCRD;
                  end else begin
                     st <= S_FIN;
                  end
               end else begin
                  st <= S_RDA;
               end
            end
            S_RCRD: st <= S_RCWR;
            S_RCWR: begin
               first <= 1'b0;
               carry <= add_cout;
               if (rd_ch.wm) st <= S_FIN;
               else begin
                  b_ptr <= b_ptr - STEP;
                  st    <= S_RCRD;
               end
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R10
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);

   // R10
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ovf && !mem_wr) |=> !ovf);

   // R6
   ovf_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(mem_wr) && $past(mem_wdata[5:4]) == ZN_OVF));

   // R9
   zone_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_addr != b_unit && !ovf_hit) |-> mem_wdata[5:4] == ZN_NONE);

   // R9
   digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata[3:0] <= 4'd9);
endmodule

// File: tb/dec_field_adder_test.sv
`timescale 1ns/1ps
module dec_field_adder_test;
   localparam int AW = 8;
   localparam int AU = 40;
   localparam int BU = 120;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          sub = 1'b0;
   logic          clr_ovf = 1'b0;
   logic [AW-1:0] a_addr = '0;
   logic [AW-1:0] b_addr = '0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, done, ovf;
   logic [6:0]    mem_wdata;
   logic [6:0]    mem_rdata;
   logic [6:0]    mem [0:255];

   int checks = 0;
   int errors = 0;
   bit ovf_model = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dec_field_adder #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
      .a_addr(a_addr), .b_addr(b_addr), .clr_ovf(clr_ovf),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .ovf(ovf)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint p10(input int n);
      longint r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

   task automatic put_field(input int unit, input int len, input longint mag,
                            input bit neg, input bit noisy);
      for (int i = 0; i < len; i++) begin
         logic [3:0] num;
         logic [1:0] zn;
         num = 4'((mag / p10(i)) % 10);
         if (noisy && num == 0 && ($urandom % 2) == 1) num = 4'hC;
         if (i == 0) begin
            if (neg) zn = 2'b10;
            else if (noisy) begin
               case ($urandom % 3)
                  0: zn = 2'b11;
                  1: zn = 2'b00;
                  default: zn = 2'b01;
               endcase
            end else zn = 2'b11;
         end else zn = noisy ? 2'($urandom % 4) : 2'b00;
         mem[unit - i] = {(i == len - 1), zn, num};
      end
   endtask

   task automatic run_case(input string tag, input int la, input int lb,
                           input longint amag, input bit aneg,
                           input longint bmag, input bit bneg,
                           input bit sub_op, input bit same, input bit noisy,
                           input bit pre_clr);
      logic [6:0] a_snap [0:15];
      longint ae, res, lim;
      bit an, straight, recomp, rneg, flag;
      int k, exp_k, au;
      if (pre_clr) begin
         @(negedge clk) clr_ovf = 1'b1;
         @(negedge clk) clr_ovf = 1'b0;
         ovf_model = 1'b0;
      end
      lim = p10(lb);
      put_field(BU, lb, bmag, bneg, noisy);
      mem[BU + 1]  = 7'h2A;
      mem[BU - lb] = 7'h15;
      if (same) begin
         au = BU; ae = bmag; an = bneg;
      end else begin
         au = AU;
         put_field(AU, la, amag, aneg, noisy);
         for (int i = 0; i < la; i++) a_snap[i] = mem[AU - i];
         ae = (la > lb) ? (amag % lim) : amag;
         an = aneg;
      end
      straight = !(an ^ bneg ^ sub_op);
      recomp = 1'b0; flag = 1'b0;
      if (straight) begin
         res = bmag + ae;
         flag = (res >= lim) && (lb > 1);
         res = res % lim;
         rneg = bneg;
      end else if (bmag >= ae) begin
         res = bmag - ae; rneg = bneg;
      end else begin
         res = ae - bmag; rneg = !bneg; recomp = 1'b1;
      end
      ovf_model = ovf_model | flag;
      exp_k = 3 * lb + 1 + (recomp ? 2 * lb : 0);

      @(negedge clk);
      a_addr = AW'(au); b_addr = AW'(BU); sub = sub_op; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 400) begin
         @(negedge clk);
         k++;
      end
      // R11: done latency tells which passes ran
      chk(k == exp_k, "R11", "done latency", k, exp_k);

      for (int i = 0; i < lb; i++) begin
         logic [6:0] e;
         logic [1:0] ez;
         if (i == 0) ez = rneg ? 2'b10 : 2'b11;
         else if (i == lb - 1 && flag) ez = 2'b01;
         else ez = 2'b00;
         e = {(i == lb - 1), ez, 4'((res / p10(i)) % 10)};
         chk(mem[BU - i] == e, (i == 0) ? tag : "R9", "result char",
             longint'(mem[BU - i]), longint'(e));
      end
      // R8: nothing outside the B-field written, A-field untouched
      chk(mem[BU + 1] == 7'h2A, "R8", "guard after units", longint'(mem[BU + 1]), 42);
      chk(mem[BU - lb] == 7'h15, "R8", "guard before field", longint'(mem[BU - lb]), 21);
      if (!same)
         for (int i = 0; i < la; i++)
            chk(mem[AU - i] == a_snap[i], "R8", "A-field unchanged",
                longint'(mem[AU - i]), longint'(a_snap[i]));
      chk(ovf == ovf_model, flag ? "R6" : ((lb == 1) ? "R7" : "R10"), "overflow flag",
          longint'(ovf), longint'(ovf_model));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R11 watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) mem[i] = 7'h00;
      repeat (3) @(negedge clk);
      // R11 / R10: reset state
      chk(done == 1'b0, "R11", "done in reset", longint'(done), 0);
      chk(ovf == 1'b0, "R10", "ovf in reset", longint'(ovf), 0);
      chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R11", "port idle in reset",
          longint'({mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_case("R2", 4, 4, 567, 0, 1234, 0, 0, 0, 0, 1);
      run_case("R5", 3, 3, 200, 1, 500, 1, 0, 0, 0, 1);
      run_case("R5", 3, 3, 100, 1, 300, 0, 1, 0, 0, 1);
      run_case("R4", 2, 2, 70, 0, 25, 0, 1, 0, 0, 1);
      run_case("R3", 2, 2, 25, 0, 70, 0, 1, 0, 0, 1);
      run_case("R3", 3, 3, 55, 0, 55, 0, 1, 0, 0, 1);
      run_case("R6", 3, 3, 1, 0, 999, 0, 0, 0, 0, 1);
      run_case("R10", 2, 2, 1, 0, 10, 0, 0, 0, 0, 0);
      @(negedge clk) clr_ovf = 1'b1;
      @(negedge clk) clr_ovf = 1'b0;
      ovf_model = 1'b0;
      chk(ovf == 1'b0, "R10", "ovf after clear pulse", longint'(ovf), 0);
      run_case("R7", 1, 1, 9, 0, 9, 0, 0, 0, 0, 1);
      run_case("R8", 2, 5, 47, 0, 12345, 0, 0, 0, 0, 1);
      run_case("R8", 6, 3, 987654, 0, 100, 0, 1, 0, 0, 1);
      run_case("R3", 4, 4, 0, 1, 4321, 1, 1, 1, 0, 1);
      run_case("R2", 3, 3, 0, 0, 678, 0, 0, 1, 0, 1);
      run_case("R1", 3, 3, 305, 0, 402, 1, 0, 0, 1, 1);
      run_case("R9", 4, 4, 1000, 0, 2003, 0, 0, 0, 1, 1);

      for (int n = 0; n < 150; n++) begin
         int la, lb;
         longint am, bm;
         bit an, bn, so, sm, nz;
         string tg;
         la = 1 + int'($urandom % 7);
         lb = 1 + int'($urandom % 6);
         am = longint'($urandom) % p10(la);
         bm = longint'($urandom) % p10(lb);
         an = 1'($urandom); bn = 1'($urandom); so = 1'($urandom);
         sm = ($urandom % 8) == 0;
         nz = 1'($urandom);
         if (sm) la = lb;
         if (sm ? (so == 1'b0) : ((an ^ bn ^ so) == 1'b0)) tg = "R2";
         else tg = "R3";
         run_case(tg, la, lb, am, an, bm, bn, so, sm, nz, 1);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule